// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to sixteen interrupt sources into a pending register and gates them with an enable register. Each source raises its pending bit with a one-cycle set pulse. Whenever any pending bit is also enabled, a single level-sensitive interrupt line to the CPU is high. The controller always presents the level that would win arbitration, together with that level's vector address.

When the CPU strobes acknowledge, the winning level's pending bit is cleared and the line is re-evaluated. Software reaches both registers through four byte addresses on a simple register bus. Software may clear pending bits, but it can never set them. Enable writes are filtered by a parameter mask that names the implemented levels, so a smaller variant of the block differs only in that mask.

Top module: `irq_vec_ctrl`

## Requirements
- R1: `irqOut` is high exactly when at least one level has both its pending bit and its enable bit set.
- R2: Any pending and enabled level in 8..15 wins arbitration over every level in 0..7.
- R3: Within one byte of levels, the lowest-numbered pending and enabled level wins.
- R4: `ackVector` equals 0x7FF8 minus twice `ackLevel`.
- R5: An `ackStrobe` with a winner present clears only the winner's pending bit, on the next clock edge.
- R6: A bus write to a pending half (address 0 for levels 0..7, address 1 for levels 8..15, with data bit k mapping to level k of that half) ANDs the data into that half. Writing 0 clears a bit, and writing 1 leaves it unchanged.
- R7: A bus write to an enable half (address 2 for the low half, address 3 for the high half) stores the data ANDed with `LEVEL_MASK`. The default mask is 0xDFFF, so enable bit 13 always reads 0.
- R8: A synchronous `rst` clears both the pending and the enable registers.
- R9: A `srcSet` pulse on a level wins over a clearing bus write to that level in the same cycle.
- R10: With no pending and enabled level, `ackNone` is 1 and `ackLevel` is 0. An `ackStrobe` in that state changes no register.
- R11: `busRdata` returns, without a clock delay, the byte selected by `busAddr`: 0 is pending low, 1 is pending high, 2 is enable low, and 3 is enable high.
- R12: A `srcSet` pulse sets its pending bit whatever the enable state. A pending bit whose enable bit is clear does not raise `irqOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | Register bus select |
| busWr | input | 1 | Write qualifier (1 means write) |
| busAddr | input | 2 | Register byte address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr |
| srcSet | input | 16 | One-cycle set pulses, one per level |
| ackStrobe | input | 1 | CPU acknowledge strobe |
| irqOut | output | 1 | Level interrupt line to the CPU |
| ackLevel | output | 4 | Winning level |
| ackVector | output | 16 | Vector address of the winning level |
| ackNone | output | 1 | No level is pending and enabled |

## Verification
The checks on acknowledge clearing and on "software cannot set" assume that no `srcSet` pulse arrives in the same cycle, because a pulse may legally re-set the bit. Those properties are therefore gated on an idle `srcSet`. `rst` is taken to be synchronous, and bus and source inputs are taken to change only between clock edges. The stimulus drives every input on the falling edge and holds each pulse for exactly one cycle. The bench makes a single, deliberate same-cycle overlap of a set pulse with a clearing write, to exercise R9.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int BYTE_W = 8;
  localparam logic [1:0] ADDR_PEND_LO = 2'd0;
  localparam logic [1:0] ADDR_PEND_HI = 2'd1;
  localparam logic [1:0] ADDR_EN_LO   = 2'd2;
  localparam logic [1:0] ADDR_EN_HI   = 2'd3;

  typedef struct packed {
    logic       wrPendLo;
    logic       wrPendHi;
    logic       wrEnLo;
    logic       wrEnHi;
    logic       ackClr;
    logic [3:0] ackLevel;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_control.sv
module irq_control
  import pvic_pkg::*;
#(
  parameter int LEVELS = 16,
  parameter logic [15:0] VEC_BASE = 16'h7FF8
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic              ackStrobe,
  input  logic [LEVELS-1:0] active,
  output ctrlStrobes_t      strobes,
  output logic [3:0]        winLevel,
  output logic [15:0]       winVector,
  output logic              winNone
);
  localparam int HALF  = LEVELS / 2;
  localparam int LVL_W = $clog2(LEVELS);

  logic found;
  logic [LVL_W-1:0] lvl;

  // Scan priority slots; slot p tests level p XOR HALF (upper byte first).
  always_comb begin
    found    = 1'b0;
    winLevel = '0;
    lvl      = '0;
    for (int p = 0; p < LEVELS; p++) begin
      lvl = LVL_W'(p) ^ LVL_W'(HALF);
      if (!found && active[lvl]) begin
        found    = 1'b1;
        winLevel = lvl;
      end
    end
  end

  assign winNone   = !found;
  assign winVector = VEC_BASE - {11'd0, winLevel, 1'b0};

  always_comb begin
    strobes          = '0;
    strobes.wrPendLo = busSel && busWr && (busAddr == ADDR_PEND_LO);
    strobes.wrPendHi = busSel && busWr && (busAddr == ADDR_PEND_HI);
    strobes.wrEnLo   = busSel && busWr && (busAddr == ADDR_EN_LO);
    strobes.wrEnHi   = busSel && busWr && (busAddr == ADDR_EN_HI);
    strobes.ackClr   = ackStrobe && found;
    strobes.ackLevel = winLevel;
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import pvic_pkg::*;
#(
  parameter int LEVELS = 16,
  parameter logic [15:0] LEVEL_MASK = 16'hDFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [1:0]        busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  input  logic [LEVELS-1:0] srcSet,
  output logic [LEVELS-1:0] pendQ,
  output logic [LEVELS-1:0] enQ,
  output logic [LEVELS-1:0] active,
  output logic [BYTE_W-1:0] busRdata
);
  localparam int HALF = LEVELS / 2;

  for (genvar i = 0; i < LEVELS; i++) begin : g_bit
    localparam bit IS_HI = (i >= HALF);
    localparam int COL   = i % HALF;
    logic wrPend, wrEn;
    assign wrPend = IS_HI ? strobes.wrPendHi : strobes.wrPendLo;
    assign wrEn   = IS_HI ? strobes.wrEnHi   : strobes.wrEnLo;

    always_ff @(posedge clk) begin
      if (rst) begin
        pendQ[i] <= 1'b0;
        enQ[i]   <= 1'b0;
      end else begin
        if (srcSet[i])
          pendQ[i] <= 1'b1;
        else if ((wrPend && !busWdata[COL]) ||
                 (strobes.ackClr && strobes.ackLevel == 4'(i)))
          pendQ[i] <= 1'b0;
        if (wrEn)
          enQ[i] <= busWdata[COL] & LEVEL_MASK[i];
      end
    end
  end

  assign active = pendQ & enQ;

  always_comb begin
    case (busAddr)
      ADDR_PEND_LO: busRdata = pendQ[HALF-1:0];
      ADDR_PEND_HI: busRdata = pendQ[LEVELS-1:HALF];
      ADDR_EN_LO:   busRdata = enQ[HALF-1:0];
      default:      busRdata = enQ[LEVELS-1:HALF];
    endcase
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import pvic_pkg::*;
#(
  parameter logic [15:0] LEVEL_MASK = 16'hDFFF,
  parameter logic [15:0] VEC_BASE   = 16'h7FF8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [1:0]  busAddr,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  input  logic [15:0] srcSet,
  input  logic        ackStrobe,
  output logic        irqOut,
  output logic [3:0]  ackLevel,
  output logic [15:0] ackVector,
  output logic        ackNone
);
  localparam int LEVELS = 2 * BYTE_W;

  ctrlStrobes_t      strobes;
  logic [LEVELS-1:0] pendQ, enQ, active;

  irq_control #(.LEVELS(LEVELS), .VEC_BASE(VEC_BASE)) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .ackStrobe(ackStrobe),
    .active(active), .strobes(strobes), .winLevel(ackLevel),
    .winVector(ackVector), .winNone(ackNone)
  );

  irq_datapath #(.LEVELS(LEVELS), .LEVEL_MASK(LEVEL_MASK)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .busAddr(busAddr),
    .busWdata(busWdata), .srcSet(srcSet), .pendQ(pendQ), .enQ(enQ),
    .active(active), .busRdata(busRdata)
  );

  assign irqOut = |active;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter logic [15:0] LEVEL_MASK = 16'hDFFF
) (
  input logic        clk,
  input logic        rst,
  input logic        busSel,
  input logic        busWr,
  input logic [15:0] srcSet,
  input logic        ackStrobe,
  input logic        irqOut,
  input logic [3:0]  ackLevel,
  input logic        ackNone,
  input logic [15:0] pendQ,
  input logic [15:0] enQ
);
  // R1
  irq_matches_winner_chk: assert property (@(posedge clk) disable iff (rst)
    irqOut == !ackNone);

  // R2
  upper_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!ackNone && ackLevel < 4'd8) |-> ((pendQ[15:8] & enQ[15:8]) == 8'h00));

  // R3
  winner_active_chk: assert property (@(posedge clk) disable iff (rst)
    !ackNone |-> (pendQ[ackLevel] && enQ[ackLevel]));

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ackStrobe && !ackNone && srcSet == 16'h0) |=> !pendQ[$past(ackLevel)]);

  // R6
  pend_no_sw_set_chk: assert property (@(posedge clk) disable iff (rst)
    (srcSet == 16'h0) |=> ((pendQ & ~$past(pendQ)) == 16'h0));

  // R7
  enable_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (enQ & ~LEVEL_MASK) == 16'h0);

  // R10
  ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (ackStrobe && ackNone && srcSet == 16'h0 && !(busSel && busWr))
      |=> (pendQ == $past(pendQ) && enQ == $past(enQ)));

  // R8
  reset_clears_chk: assert property (@(posedge clk)
    $past(rst) |-> (pendQ == 16'h0 && enQ == 16'h0));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.LEVEL_MASK(LEVEL_MASK)) u_chk (
  .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .srcSet(srcSet),
  .ackStrobe(ackStrobe), .irqOut(irqOut), .ackLevel(ackLevel),
  .ackNone(ackNone), .pendQ(pendQ), .enQ(enQ)
);

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [7:0]  busWdata = 8'h00;
  logic [7:0]  busRdata;
  logic [15:0] srcSet = 16'h0;
  logic        ackStrobe = 1'b0;
  logic        irqOut, ackNone;
  logic [3:0]  ackLevel;
  logic [15:0] ackVector;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irq_vec_ctrl dut (
    .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcSet(srcSet),
    .ackStrobe(ackStrobe), .irqOut(irqOut), .ackLevel(ackLevel),
    .ackVector(ackVector), .ackNone(ackNone)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  task automatic pulse(input logic [15:0] s);
    @(negedge clk);
    srcSet = s;
    @(negedge clk);
    srcSet = 16'h0;
  endtask

  task automatic ackOnce();
    @(negedge clk);
    ackStrobe = 1'b1;
    @(negedge clk);
    ackStrobe = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      readReg(2'(a), d);
      chk("R8 reset reg", {8'h0, d}, 16'h0);
    end
    chk("R1 irq after reset", {15'h0, irqOut}, 16'h0);
    chk("R10 none after reset", {15'h0, ackNone}, 16'h1);
  endtask

  task automatic testEnableMask();
    logic [7:0] d;
    busWrite(2'd2, 8'hFF);
    busWrite(2'd3, 8'hFF);
    readReg(2'd3, d);
    chk("R7 en hi masked", {8'h0, d}, 16'h00DF);
    readReg(2'd2, d);
    chk("R11 en lo readback", {8'h0, d}, 16'h00FF);
  endtask

  task automatic testArbitration();
    logic [7:0] d;
    pulse(16'h0028);
    readReg(2'd0, d);
    chk("R12 pend lo set", {8'h0, d}, 16'h0028);
    chk("R1 irq high", {15'h0, irqOut}, 16'h1);
    chk("R3 lowest in byte", {12'h0, ackLevel}, 16'd3);
    chk("R4 vector L3", ackVector, 16'h7FF2);
    pulse(16'h0200);
    chk("R2 upper byte wins", {12'h0, ackLevel}, 16'd9);
    chk("R4 vector L9", ackVector, 16'h7FE6);
  endtask

  task automatic testAck();
    logic [7:0] d;
    ackOnce();
    readReg(2'd1, d);
    chk("R5 winner cleared", {8'h0, d}, 16'h0);
    readReg(2'd0, d);
    chk("R5 others kept", {8'h0, d}, 16'h0028);
    chk("R5 next winner", {12'h0, ackLevel}, 16'd3);
  endtask

  task automatic testPendWrite();
    logic [7:0] d;
    busWrite(2'd0, 8'hF7);
    readReg(2'd0, d);
    chk("R6 write zero clears", {8'h0, d}, 16'h0020);
    busWrite(2'd0, 8'hFF);
    readReg(2'd0, d);
    chk("R6 write one no set", {8'h0, d}, 16'h0020);
    chk("R4 vector L5", ackVector, 16'h7FEE);
  endtask

  task automatic testIdleAck();
    logic [7:0] d;
    busWrite(2'd2, 8'h00);
    chk("R12 disabled no irq", {15'h0, irqOut}, 16'h0);
    chk("R10 none flag", {15'h0, ackNone}, 16'h1);
    chk("R10 level zero", {12'h0, ackLevel}, 16'd0);
    ackOnce();
    readReg(2'd0, d);
    chk("R10 pend unchanged", {8'h0, d}, 16'h0020);
    readReg(2'd3, d);
    chk("R10 en unchanged", {8'h0, d}, 16'h00DF);
  endtask

  task automatic testSetBeatsClear();
    logic [7:0] d;
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 2'd0; busWdata = 8'h00;
    srcSet = 16'h0002;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; srcSet = 16'h0;
    readReg(2'd0, d);
    chk("R9 set wins", {8'h0, d}, 16'h0002);
    pulse(16'h2000);
    readReg(2'd1, d);
    chk("R12 pend bit13 set", {8'h0, d}, 16'h0020);
    chk("R7 bit13 not enabled", {15'h0, irqOut}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testEnableMask();
    testArbitration();
    testAck();
    testPendWrite();
    testIdleAck();
    testSetBeatsClear();
    doReset();
    testReset();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule